// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a small shared-memory machine. It keeps one directory entry per memory block, holding a sharing state, a presence vector with one bit per processor, and the identity of the current owner. Caches send it read misses, write misses and eviction write-backs. It answers by sending invalidations, fetches or combined fetch-and-invalidate messages to the caches that hold the block. When those are resolved it sends a data reply to the requester. The block's data lives in an internal memory array.

Only one transaction is open at a time. While it is open the request port is held not-ready, so a second request to the same block, or to any other block, waits until the first one completes. Invalidation acknowledgements are counted. The reply to a write miss is not released until the count of outstanding invalidations returns to zero. When an exclusive block is recalled, the data comes back on a dedicated fetch-data port and is written into memory before it is forwarded to the requester.

Top module: `coh_home_dir`

## Requirements
- R1: After reset, every block is uncached, with no sharers and zero data. `req_ready` is high, and `msg_valid` and `rep_valid` are low.
- R2: A read miss (`req_kind` 0) to an uncached or shared block sends no message. It replies with the memory data one cycle after acceptance and adds the requester to the sharers.
- R3: A read miss to an exclusive block sends one fetch (`msg_kind` 1) to the owner. The returned data is written to memory and replied to the requester. Afterwards the block is shared by the old owner and the requester.
- R4: A write miss (`req_kind` 1) to a shared block sends one invalidate (`msg_kind` 0) to every sharer other than the requester. It sends one per cycle, lowest processor index first. `msg_kind` is never 3.
- R5: The write-miss reply is held until the number of `ack_valid` pulses equals the number of invalidations sent.
- R6: A write miss to a block held exclusive by another processor sends one fetch-and-invalidate (`msg_kind` 2) to the owner. The returned data is written to memory and replied. Every write miss leaves the requester as the sole exclusive owner, with the reply carrying the block's data.
- R7: A write-back (`req_kind` 2) from the exclusive owner writes `req_data` to memory. It returns the block to uncached with no sharers, and it produces no message or reply.
- R8: A write-back from a non-owner, or to a block that is not exclusive, has no effect. `req_kind` 3 also has no effect.
- R9: A read or write miss drops `req_ready` from the cycle after acceptance until the cycle after its single-cycle reply, so later requests are held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request accepted on this edge |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 unused |
| req_proc | input | PW | Requesting processor |
| req_addr | input | AW | Block index |
| req_data | input | DW | Write-back data |
| msg_valid | output | 1 | Message to a remote cache |
| msg_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate |
| msg_dest | output | PW | Destination processor |
| msg_addr | output | AW | Block index of the message |
| ack_valid | input | 1 | One invalidation acknowledgement |
| fetch_valid | input | 1 | Owner data returned |
| fetch_data | input | DW | Returned block data |
| rep_valid | output | 1 | Data reply to requester |
| rep_proc | output | PW | Reply destination |
| rep_addr | output | AW | Reply block index |
| rep_data | output | DW | Reply data |

## Verification
Two events can fall in the same cycle: issuing an invalidation and receiving an acknowledgement, whether for that invalidation or for an earlier one. The bench provokes this by randomly raising `ack_valid` in the very cycle an invalidate first becomes visible, and by also delaying acknowledgements by random amounts. It is judged by comparing the reply timing against the bench's own tally of unacknowledged invalidations, which must be zero when the reply appears. It also checks that the set and order of invalidated processors match the bench's model of the presence vector.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [1:0] {BLK_UNC = 2'd0, BLK_SHR = 2'd1, BLK_EXC = 2'd2} blk_t;
   typedef enum logic [2:0] {ST_IDLE, ST_INV, ST_ACK, ST_FETCH, ST_WDATA, ST_REPLY} fsm_t;
   localparam logic [1:0] RQ_READ  = 2'd0;
   localparam logic [1:0] RQ_WRITE = 2'd1;
   localparam logic [1:0] RQ_WBACK = 2'd2;
   localparam logic [1:0] MS_INV   = 2'd0;
   localparam logic [1:0] MS_FETCH = 2'd1;
   localparam logic [1:0] MS_FINV  = 2'd2;
endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store import coh_pkg::*; #(
   parameter int NPROC = 4,
   parameter int NBLK  = 16,
   parameter int DW    = 16,
   localparam int PW = $clog2(NPROC),
   localparam int AW = $clog2(NBLK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    rd_addr,
   output blk_t             rd_st,
   output logic [NPROC-1:0] rd_pres,
   output logic [PW-1:0]    rd_own,
   output logic [DW-1:0]    rd_data,
   input  logic             dir_we,
   input  logic             mem_we,
   input  logic [AW-1:0]    wr_addr,
   input  blk_t             wr_st,
   input  logic [NPROC-1:0] wr_pres,
   input  logic [PW-1:0]    wr_own,
   input  logic [DW-1:0]    wr_data
);
   blk_t             st_q   [NBLK];
   logic [NPROC-1:0] pres_q [NBLK];
   logic [PW-1:0]    own_q  [NBLK];
   logic [DW-1:0]    mem_q  [NBLK];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NBLK; b++) begin
            st_q[b]   <= BLK_UNC;
            pres_q[b] <= '0;
            own_q[b]  <= '0;
            mem_q[b]  <= '0;
         end
      end else begin
         if (dir_we) begin
            st_q[wr_addr]   <= wr_st;
            pres_q[wr_addr] <= wr_pres;
            own_q[wr_addr]  <= wr_own;
         end
         if (mem_we) mem_q[wr_addr] <= wr_data;
      end
   end

   assign rd_st   = st_q[rd_addr];
   assign rd_pres = pres_q[rd_addr];
   assign rd_own  = own_q[rd_addr];
   assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/coh_low_pick.sv
module coh_low_pick #(
   parameter int N = 4,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (vec[k]) idx = IW'(k);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/coh_ack_ctr.sv
module coh_ack_ctr #(
   parameter int NPROC = 4,
   localparam int CW = $clog2(NPROC) + 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sent,
   input  logic acked,
   output logic zero
);
   logic [CW-1:0] cnt_q;
   always_ff @(posedge clk) begin
      if (!rst_n)               cnt_q <= '0;
      else if (sent && !acked)  cnt_q <= cnt_q + CW'(1);
      else if (!sent && acked)  cnt_q <= cnt_q - CW'(1);
   end
   assign zero = (cnt_q == '0);
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir import coh_pkg::*; #(
   parameter int NPROC = 4,
   parameter int NBLK  = 16,
   parameter int DW    = 16,
   localparam int PW = $clog2(NPROC),
   localparam int AW = $clog2(NBLK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [1:0]    req_kind,
   input  logic [PW-1:0] req_proc,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   output logic          msg_valid,
   output logic [1:0]    msg_kind,
   output logic [PW-1:0] msg_dest,
   output logic [AW-1:0] msg_addr,
   input  logic          ack_valid,
   input  logic          fetch_valid,
   input  logic [DW-1:0] fetch_data,
   output logic          rep_valid,
   output logic [PW-1:0] rep_proc,
   output logic [AW-1:0] rep_addr,
   output logic [DW-1:0] rep_data
);
   if (NPROC < 2 || NBLK < 2 || DW < 1) begin : g_bad_cfg
      $error("coh_home_dir: NPROC and NBLK must be at least 2, DW at least 1");
   end

   fsm_t             st, st_n;
   logic [1:0]       t_kind;
   logic [PW-1:0]    t_proc, t_owner;
   logic [AW-1:0]    t_addr, w_addr;
   logic [NPROC-1:0] pend, pend_n, e_pres, w_pres, me_bit, req_bit;
   logic [DW-1:0]    rdata, rdata_n, e_data, w_data;
   blk_t             e_st, w_st;
   logic [PW-1:0]    e_own, w_own, pick_idx;
   logic             dir_we, mem_we, pick_any, ack_zero;

   coh_dir_store #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_addr(req_addr),
      .rd_st(e_st), .rd_pres(e_pres), .rd_own(e_own), .rd_data(e_data),
      .dir_we(dir_we), .mem_we(mem_we), .wr_addr(w_addr),
      .wr_st(w_st), .wr_pres(w_pres), .wr_own(w_own), .wr_data(w_data));

   coh_low_pick #(.N(NPROC)) u_pick (.vec(pend), .idx(pick_idx), .any(pick_any));

   coh_ack_ctr #(.NPROC(NPROC)) u_acks (
      .clk(clk), .rst_n(rst_n), .sent(msg_valid && st == ST_INV),
      .acked(ack_valid), .zero(ack_zero));

   assign me_bit  = NPROC'(1) << t_proc;
   assign req_bit = NPROC'(1) << req_proc;

   always_comb begin
      st_n    = st;
      pend_n  = pend;
      rdata_n = rdata;
      dir_we  = 1'b0;
      mem_we  = 1'b0;
      w_addr  = t_addr;
      w_st    = BLK_UNC;
      w_pres  = '0;
      w_own   = t_proc;
      w_data  = fetch_data;
      case (st)
         ST_IDLE: begin
            w_addr = req_addr;
            w_own  = req_proc;
            if (req_valid) begin
               rdata_n = e_data;
               case (req_kind)
                  RQ_READ: begin
                     if (e_st == BLK_EXC) st_n = ST_FETCH;
                     else begin
                        dir_we = 1'b1; w_st = BLK_SHR; w_pres = e_pres | req_bit;
                        w_own = e_own; st_n = ST_REPLY;
                     end
                  end
                  RQ_WRITE: begin
                     if (e_st == BLK_EXC && e_own != req_proc) st_n = ST_FETCH;
                     else if (e_st == BLK_SHR && (e_pres & ~req_bit) != '0) begin
                        pend_n = e_pres & ~req_bit;
                        st_n   = ST_INV;
                     end else begin
                        dir_we = 1'b1; w_st = BLK_EXC; w_pres = req_bit; st_n = ST_REPLY;
                     end
                  end
                  RQ_WBACK: begin
                     if (e_st == BLK_EXC && e_own == req_proc) begin
                        dir_we = 1'b1; mem_we = 1'b1; w_data = req_data; w_own = '0;
                     end
                  end
                  default: ;
               endcase
            end
         end
         ST_INV: begin
            pend_n = pend & ~(NPROC'(1) << pick_idx);
            if (pend_n == '0) st_n = ST_ACK;
         end
         ST_ACK: begin
            if (ack_zero) begin
               dir_we = 1'b1; w_st = BLK_EXC; w_pres = me_bit; st_n = ST_REPLY;
            end
         end
         ST_FETCH: st_n = ST_WDATA;
         ST_WDATA: begin
            if (fetch_valid) begin
               mem_we  = 1'b1;
               dir_we  = 1'b1;
               rdata_n = fetch_data;
               st_n    = ST_REPLY;
               if (t_kind == RQ_READ) begin
                  w_st = BLK_SHR; w_pres = me_bit | (NPROC'(1) << t_owner); w_own = t_owner;
               end else begin
                  w_st = BLK_EXC; w_pres = me_bit;
               end
            end
         end
         ST_REPLY: st_n = ST_IDLE;
         default:  st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE; pend <= '0; rdata <= '0;
         t_kind <= '0; t_proc <= '0; t_owner <= '0; t_addr <= '0;
      end else begin
         st    <= st_n;
         pend  <= pend_n;
         rdata <= rdata_n;
         if (st == ST_IDLE && req_valid) begin
            t_kind  <= req_kind;
            t_proc  <= req_proc;
            t_addr  <= req_addr;
            t_owner <= e_own;
         end
      end
   end

   assign req_ready = (st == ST_IDLE);
   assign msg_valid = (st == ST_INV && pick_any) || st == ST_FETCH;
   assign msg_kind  = (st == ST_INV) ? MS_INV : ((t_kind == RQ_WRITE) ? MS_FINV : MS_FETCH);
   assign msg_dest  = (st == ST_INV) ? pick_idx : t_owner;
   assign msg_addr  = t_addr;
   assign rep_valid = (st == ST_REPLY);
   assign rep_proc  = t_proc;
   assign rep_addr  = t_addr;
   assign rep_data  = rdata;
endmodule

// File: rtl/coh_home_dir_chk.sv
module coh_home_dir_chk #(
   parameter int NPROC = 4,
   localparam int OW = $clog2(NPROC) + 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic [1:0] req_kind,
   input logic       msg_valid,
   input logic [1:0] msg_kind,
   input logic       ack_valid,
   input logic       rep_valid
);
   logic [OW-1:0] owed;
   logic          inv_seen;
   assign inv_seen = msg_valid && msg_kind == 2'd0;

   always_ff @(posedge clk) begin
      if (!rst_n) owed <= '0;
      else owed <= owed + OW'(inv_seen) - OW'(ack_valid);
   end

   assert_reply_after_acks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rep_valid |-> owed == '0);
   assert_msg_blocks_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !req_ready);
   assert_reply_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rep_valid |=> (!rep_valid && req_ready));
   assert_msg_kind_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> msg_kind != 2'd3);
   assert_wback_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_kind == 2'd2) |=> (req_ready && !msg_valid && !rep_valid));
   assert_miss_goes_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_kind == 2'd0 || req_kind == 2'd1)) |=> !req_ready);
endmodule

bind coh_home_dir coh_home_dir_chk #(.NPROC(NPROC)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_kind(req_kind), .msg_valid(msg_valid), .msg_kind(msg_kind),
   .ack_valid(ack_valid), .rep_valid(rep_valid));

// File: tb/coh_home_dir_test.sv
`timescale 1ns/1ps
module coh_home_dir_test;
   localparam int NPROC = 4, NBLK = 16, DW = 16;
   localparam int PW = $clog2(NPROC), AW = $clog2(NBLK);
   localparam int UNC = 0, SHR = 1, EXC = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, ack_valid = 1'b0, fetch_valid = 1'b0;
   logic [1:0] req_kind = '0;
   logic [PW-1:0] req_proc = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0, fetch_data = '0;
   logic req_ready, msg_valid, rep_valid;
   logic [1:0] msg_kind;
   logic [PW-1:0] msg_dest, rep_proc;
   logic [AW-1:0] msg_addr, rep_addr;
   logic [DW-1:0] rep_data;

   always #4 clk = ~clk;

   coh_home_dir #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) uut (.*);

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   int m_st [NBLK];
   logic [NPROC-1:0] m_pres [NBLK];
   int m_own [NBLK];
   logic [DW-1:0] m_mem [NBLK];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic txn(input int k, input int p, input int a, input logic [DW-1:0] wd);
      logic [NPROC-1:0] exp_inv = '0, seen_inv = '0, pb;
      int exp_fk = -1, exp_fd = 0, got_fk = -1, got_fd = -1;
      int owed = 0, fw = 0, last = -1;
      bit replied = 0, exp_rep;
      logic [DW-1:0] fd, exp_data;
      string tg;
      pb = NPROC'(1) << p;
      fd = DW'($urandom);
      exp_rep = (k == 0 || k == 1);
      exp_data = m_mem[a];
      tg = "R2";
      if (k == 0 && m_st[a] == EXC) begin exp_fk = 1; exp_fd = m_own[a]; exp_data = fd; tg = "R3"; end
      if (k == 1) begin
         tg = "R6";
         if (m_st[a] == EXC && m_own[a] != p) begin exp_fk = 2; exp_fd = m_own[a]; exp_data = fd; end
         else if (m_st[a] == SHR) begin exp_inv = m_pres[a] & ~pb; tg = "R4"; end
      end
      @(negedge clk);
      req_valid = 1; req_kind = 2'(k); req_proc = PW'(p); req_addr = AW'(a); req_data = wd;
      @(negedge clk);
      req_valid = 0;
      if (!exp_rep) begin
         chk(req_ready && !msg_valid && !rep_valid, (k == 2) ? "R7" : "R8", int'(req_ready), 1);
         if (k == 2 && m_st[a] == EXC && m_own[a] == p) begin
            m_mem[a] = wd; m_st[a] = UNC; m_pres[a] = '0;
         end
         return;
      end
      chk(!req_ready, "R9", int'(req_ready), 0);
      for (int c = 0; c < 80 && !replied; c++) begin
         fetch_valid = 0;
         if (fw > 0) begin
            fw--;
            if (fw == 0) begin fetch_valid = 1; fetch_data = fd; end
         end
         if (msg_valid) begin
            chk(msg_addr == AW'(a), "R4", int'(msg_addr), a);
            if (msg_kind == 2'd0) begin
               chk(int'(msg_dest) > last, "R4", int'(msg_dest), last + 1);
               last = int'(msg_dest);
               seen_inv[msg_dest] = 1'b1;
               owed++;
            end else begin
               got_fk = int'(msg_kind); got_fd = int'(msg_dest);
               fw = 1 + int'($urandom % 3);
            end
         end
         if (rep_valid) begin
            replied = 1;
            chk(owed == 0, "R5", owed, 0);
            chk(rep_data == exp_data, tg, int'(rep_data), int'(exp_data));
            chk(rep_proc == PW'(p) && rep_addr == AW'(a), tg, int'(rep_proc), p);
            chk(seen_inv == exp_inv, "R4", int'(seen_inv), int'(exp_inv));
            chk(got_fk == exp_fk && (exp_fk < 0 || got_fd == exp_fd),
                (exp_fk == 2) ? "R6" : "R3", got_fk, exp_fk);
         end else begin
            ack_valid = 0;
            if (owed > 0 && ($urandom % 2) == 0) begin ack_valid = 1; owed--; end
            @(negedge clk);
         end
      end
      ack_valid = 0; fetch_valid = 0;
      if (!replied) chk(0, tg, 0, 1);
      if (k == 0) begin
         if (m_st[a] == EXC) begin
            m_mem[a] = fd; m_pres[a] = (NPROC'(1) << m_own[a]) | pb;
         end else m_pres[a] = m_pres[a] | pb;
         m_st[a] = SHR;
      end else begin
         if (exp_fk == 2) m_mem[a] = fd;
         m_st[a] = EXC; m_pres[a] = pb; m_own[a] = p;
      end
   endtask

   initial begin
      #(8 * 200000);
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      for (int b = 0; b < NBLK; b++) begin
         m_st[b] = UNC; m_pres[b] = '0; m_own[b] = 0; m_mem[b] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready && !msg_valid && !rep_valid, "R1", int'(req_ready), 1);
      // directed corner cases
      txn(0, 0, 3, '0);        // R2 read of reset memory, zero data
      txn(0, 2, 3, '0);        // R2 second sharer
      txn(1, 1, 3, '0);        // R4 R5 two invalidations
      txn(0, 3, 3, '0);        // R3 recall from exclusive owner
      txn(1, 0, 3, '0);        // R4 invalidate sharers 1 and 3
      txn(1, 2, 3, '0);        // R6 fetch-and-invalidate
      txn(2, 1, 3, 16'h5a5a);  // R8 write-back from non-owner ignored
      txn(2, 2, 3, 16'h1234);  // R7 owner write-back
      txn(0, 1, 3, '0);        // R2 reads back write-back data
      txn(2, 1, 3, 16'hdead);  // R8 write-back to shared block ignored
      txn(3, 0, 3, 16'hbeef);  // R8 unused request kind
      txn(1, 1, 3, '0);        // R6 upgrade by sole sharer, no messages
      txn(1, 1, 3, '0);        // R6 write miss by current owner
      for (int p = 0; p < NPROC; p++) txn(0, p, 5, '0);
      txn(1, NPROC - 1, 5, '0); // R4 invalidate all but the highest
      for (int i = 0; i < 400; i++) begin
         int k, p, a;
         k = int'($urandom % 4);
         p = int'($urandom % NPROC);
         a = int'($urandom % 4);
         if (k == 0 && m_st[a] == EXC && m_own[a] == p) k = 1;
         txn(k, p, a, DW'($urandom));
      end
      finish_run();
   end
endmodule